// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable register-based model of a synchronous static memory. It can take a new read or a new write on every clock with no idle cycle between them. Each command is loaded with its address on one enabled clock edge. The transfer it starts completes two enabled edges later. A read then presents its word on the output. A write takes its word from the input at that point. Because reads and writes have the same latency, the data path never needs a turnaround gap. A clock enable stalls the whole pipeline, including any word already being presented.

A command is loaded when `adv_ld` is low. It is a read, a write or a deselect, depending on `rw` and on the three chip selects. When `adv_ld` is high, the stored base address is stepped by a two-bit beat counter and the previous operation is repeated. The step is linear or interleaved, as chosen by `burst_mode`, and it wraps inside the aligned group of four words. Byte-lane write enables are taken together with each command. A write is held in a pending register for one enabled edge before it reaches the array. A read that meets that pending write takes the new lanes directly from it.

The command decoder is a state machine with three states:
- `ST_DESEL`: no burst is open.
- `ST_RD_BURST`: a read burst is open.
- `ST_WR_BURST`: a write burst is open.

It has four transitions:
- LOAD_RD: load while selected, with `rw` high, goes to `ST_RD_BURST`.
- LOAD_WR: load while selected, with `rw` low, goes to `ST_WR_BURST`.
- DESELECT: load while not selected goes to `ST_DESEL`.
- CONTINUE: `adv_ld` high keeps the current state and advances the beat counter.

The bus is modelled as three signals: `din`, `dout` and `dout_en`.

Top module: `zbt_sram_model`

## Requirements
- R1: The part is selected only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1. A load under any other combination is a deselect: it writes nothing, and `dout_en` stays 0 in the cycle where its data would appear.
- R2: A read loaded on an enabled edge makes `dout` show the addressed word, with `dout_en`=1 (while `oe_n`=0), right after the second following enabled edge. This holds even when a read is loaded on every consecutive enabled edge.
- R3: A write loaded on an enabled edge stores the `din` value present at the second following enabled edge. Writes and reads may alternate on consecutive edges with no gap.
- R4: An edge with `cke_n`=1 is ignored. No command is taken, the pipeline does not advance, and `dout` and `dout_en` keep their values. Such edges do not count toward the two-edge latency.
- R5: After the first clock edge with `rst_n`=0, `dout_en` is 0 and no read or write is pending.
- R6: `dout_en` is combinationally 1 only while `oe_n`=0 and read data is being presented. It is never 1 in the data phase of a write or of a deselect.
- R7: Bit i of `bw_n`, taken with the command, controls data bits [9i+8:9i]. Value 0 updates that lane; value 1 leaves it unchanged.
- R8: An edge with `adv_ld`=1 repeats the previous operation at the next burst address, whatever the chip selects. After a deselect it remains a deselect.
- R9: With `burst_mode`=0, the two low address bits of beat n are (base+n) mod 4. With `burst_mode`=1, they are base XOR n. Upper address bits stay fixed, and the fifth beat returns to the base address.
- R10: A read loaded one edge after a write to the same address returns the new lanes of that write, merged with the old contents of the lanes it left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high stalls everything |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 loads a new command, 1 continues the burst |
| rw | input | 1 | 1 read, 0 write (used on load) |
| addr | input | AW | Word address (used on load) |
| bw_n | input | NL | Per-lane write enables, active low |
| burst_mode | input | 1 | 0 linear, 1 interleaved burst order |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | NL*LW | Write data, sampled two enabled edges after its command |
| dout | output | NL*LW | Read data |
| dout_en | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The hardest case to reach from the ports is a read that meets a write still waiting in the pending register. The read must be loaded exactly one enabled edge after a partial write to the same address. The earlier full write must by then have already reached the array. The stimulus issues two writes and then a read to one address on three consecutive edges, so that the merged word can only be right if forwarding works per lane. Stalled edges placed between a read and its data phase, and bursts that cross the wrap point in both orders, cover the latency counting and the address sequencing.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // operation carried down the pipeline
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // command decoder state: which burst is open
    typedef enum logic [1:0] {
        ST_DESEL    = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } bst_e;

endpackage

// File: rtl/zbt_cmd_fsm.sv
module zbt_cmd_fsm
    import zbt_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic          sel,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [NL-1:0] bw_n,
    input  logic          mode,
    output op_e           s1_op,
    output logic [AW-1:0] s1_addr,
    output logic [NL-1:0] s1_bw_n
);

    localparam int GW = 2;   // beat counter width: four-word group

    bst_e          st_q, st_d;
    logic [AW-1:0] base_q, base_d;
    logic [GW-1:0] cnt_q, cnt_d;
    logic [GW-1:0] off;
    logic [AW-1:0] a_d;
    op_e           op_d;

    // next state, burst address and issued operation
    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        cnt_d  = cnt_q + GW'(1);          // CONTINUE
        if (load) begin
            cnt_d = '0;
            if (sel) begin
                base_d = addr;
                st_d   = rw ? ST_RD_BURST : ST_WR_BURST;   // LOAD_RD / LOAD_WR
            end else begin
                st_d = ST_DESEL;                           // DESELECT
            end
        end
        off = mode ? (base_d[GW-1:0] ^ cnt_d) : (base_d[GW-1:0] + cnt_d);
        a_d = {base_d[AW-1:GW], off};
        unique case (st_d)
            ST_DESEL:    op_d = OP_NONE;
            ST_RD_BURST: op_d = OP_RD;
            ST_WR_BURST: op_d = OP_WR;
            default:     op_d = OP_NONE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_DESEL;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            st_q   <= st_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    // output register: first pipeline stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_NONE;
            s1_addr <= '0;
            s1_bw_n <= '1;
        end else if (en) begin
            s1_op   <= op_d;
            s1_addr <= a_d;
            s1_bw_n <= bw_n;
        end
    end

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 2,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  op_e              s1_op,
    input  logic [AW-1:0]    s1_addr,
    input  logic [NL-1:0]    s1_bw_n,
    input  logic [NL*LW-1:0] din,
    output op_e              s2_op,
    output logic [AW-1:0]    s2_addr,
    output logic             wb_valid,
    output logic [AW-1:0]    wb_addr,
    output logic [NL*LW-1:0] wb_data,
    output logic [NL-1:0]    wb_bw_n
);

    logic [NL-1:0] s2_bw_n;

    // second stage: address is one enabled edge old
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op   <= OP_NONE;
            s2_addr <= '0;
            s2_bw_n <= '1;
        end else if (en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
        end
    end

    // write data phase: capture din into the pending-write register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
            wb_bw_n  <= '1;
        end else if (en) begin
            wb_valid <= (s2_op == OP_WR);
            if (s2_op == OP_WR) begin
                wb_addr <= s2_addr;
                wb_data <= din;
                wb_bw_n <= s2_bw_n;
            end
        end
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array
    import zbt_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 2,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  op_e              s2_op,
    input  logic [AW-1:0]    s2_addr,
    input  logic             wb_valid,
    input  logic [AW-1:0]    wb_addr,
    input  logic [NL*LW-1:0] wb_data,
    input  logic [NL-1:0]    wb_bw_n,
    output logic             rd_valid,
    output logic [NL*LW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [NL*LW-1:0] lane_rd;

    // one storage column per byte lane, with its own forward path
    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] col [DEPTH];
        logic          hit;

        assign hit = wb_valid && !wb_bw_n[i] && (wb_addr == s2_addr);

        always_ff @(posedge clk) begin
            if (en && wb_valid && !wb_bw_n[i]) begin
                col[wb_addr] <= wb_data[i*LW +: LW];
            end
        end

        assign lane_rd[i*LW +: LW] = hit ? wb_data[i*LW +: LW] : col[s2_addr];
    end

    // read data phase: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (en) begin
            rd_valid <= (s2_op == OP_RD);
            if (s2_op == OP_RD) begin
                rd_data <= lane_rd;
            end
        end
    end

endmodule

// File: rtl/zbt_sram_model.sv
module zbt_sram_model
    import zbt_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 2,
    parameter int LW = 9,
    localparam int DW = NL * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          cs1_n,
    input  logic          cs2_n,
    input  logic          cs3,
    input  logic          adv_ld,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [NL-1:0] bw_n,
    input  logic          burst_mode,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    logic          en;
    logic          load;
    logic          sel;
    op_e           s1_op;
    logic [AW-1:0] s1_addr;
    logic [NL-1:0] s1_bw_n;
    op_e           s2_op;
    logic [AW-1:0] s2_addr;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic [NL-1:0] wb_bw_n;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    assign en   = !cke_n;
    assign load = !adv_ld;
    assign sel  = !cs1_n && !cs2_n && cs3;

    zbt_cmd_fsm #(.AW(AW), .NL(NL)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (load),
        .sel     (sel),
        .rw      (rw),
        .addr    (addr),
        .bw_n    (bw_n),
        .mode    (burst_mode),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s1_bw_n (s1_bw_n)
    );

    zbt_pipe #(.AW(AW), .NL(NL), .LW(LW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr),
        .s1_bw_n  (s1_bw_n),
        .din      (din),
        .s2_op    (s2_op),
        .s2_addr  (s2_addr),
        .wb_valid (wb_valid),
        .wb_addr  (wb_addr),
        .wb_data  (wb_data),
        .wb_bw_n  (wb_bw_n)
    );

    zbt_array #(.AW(AW), .NL(NL), .LW(LW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .s2_op    (s2_op),
        .s2_addr  (s2_addr),
        .wb_valid (wb_valid),
        .wb_addr  (wb_addr),
        .wb_data  (wb_data),
        .wb_bw_n  (wb_bw_n),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign dout    = rd_data;
    assign dout_en = rd_valid && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
    import zbt_pkg::*;
#(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          load,
    input logic          sel,
    input logic          oe_n,
    input op_e           s1_op,
    input op_e           s2_op,
    input logic          wb_valid,
    input logic          rd_valid,
    input logic [DW-1:0] dout,
    input logic          dout_en
);

    logic rst_prev = 1'b0;

    always_ff @(posedge clk) begin
        rst_prev <= !rst_n;
    end

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !oe_n);

    // R6
    write_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_WR) |=> !dout_en);

    // R2
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_RD) |=> rd_valid);

    // R3
    write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_WR) |=> wb_valid);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout) && $stable(rd_valid)));

    // R1
    deselect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load && !sel) |=> (s1_op == OP_NONE));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst_prev |-> (!rd_valid && !wb_valid));

endmodule

bind zbt_sram_model zbt_sram_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (load),
    .sel      (sel),
    .oe_n     (oe_n),
    .s1_op    (s1_op),
    .s2_op    (s2_op),
    .wb_valid (wb_valid),
    .rd_valid (rd_valid),
    .dout     (dout),
    .dout_en  (dout_en)
);

// File: tb/zbt_sram_model_tb.sv
module zbt_sram_model_tb;

    localparam int AW = 4;
    localparam int NL = 2;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam logic [2:0] SEL = 3'b001;   // {cs1_n, cs2_n, cs3}
    localparam logic [2:0] DSL = 3'b100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          cs1_n = 1'b1;
    logic          cs2_n = 1'b0;
    logic          cs3 = 1'b1;
    logic          adv_ld = 1'b0;
    logic          rw = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bw_n = '0;
    logic          burst_mode = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = !clk;

    zbt_sram_model #(.AW(AW), .NL(NL), .LW(LW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_n      (cke_n),
        .cs1_n      (cs1_n),
        .cs2_n      (cs2_n),
        .cs3        (cs3),
        .adv_ld     (adv_ld),
        .rw         (rw),
        .addr       (addr),
        .bw_n       (bw_n),
        .burst_mode (burst_mode),
        .oe_n       (oe_n),
        .din        (din),
        .dout       (dout),
        .dout_en    (dout_en)
    );

    function automatic logic [DW-1:0] dv(input int a);
        return {a[3:0], 14'h2A5C};
    endfunction

    function automatic logic [DW-1:0] ev(input int k);
        return 18'h15000 | DW'(k);
    endfunction

    // drive one cycle of inputs, take one edge, return at the falling edge
    task automatic tk(input logic [2:0] cs, input logic adv, input logic r,
                      input logic [AW-1:0] a, input logic [NL-1:0] bwn,
                      input logic [DW-1:0] d);
        {cs1_n, cs2_n, cs3} = cs;
        adv_ld = adv;
        rw     = r;
        addr   = a;
        bw_n   = bwn;
        din    = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic [DW-1:0] d);
        tk(DSL, 1'b0, 1'b1, '0, '1, d);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [DW-1:0] exp);
        chk(req, {13'b0, dout_en, dout}, {13'b0, 1'b1, exp});
    endtask

    task automatic chk_off(input string req);
        chk(req, {31'b0, dout_en}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle('0);
        idle('0);
        chk_off("R5 reset quiet");
        rst_n = 1'b1;
        idle('0);
        chk_off("R5 after release");
    endtask

    // back-to-back writes then reads
    task automatic t_b2b();
        tk(SEL, 0, 0, 0, 2'b00, '0);
        tk(SEL, 0, 0, 1, 2'b00, '0);
        tk(SEL, 0, 0, 2, 2'b00, dv(0));
        tk(SEL, 0, 0, 3, 2'b00, dv(1));
        tk(SEL, 0, 1, 0, 2'b11, dv(2));
        chk_off("R6 write phase not driven");
        tk(SEL, 0, 1, 1, 2'b11, dv(3));
        tk(SEL, 0, 1, 2, 2'b11, '0);
        chk_rd("R2 read a0", dv(0));
        tk(SEL, 0, 1, 3, 2'b11, '0);
        chk_rd("R3 read a1", dv(1));
        idle('0);
        chk_rd("R2 read a2", dv(2));
        idle('0);
        chk_rd("R3 read a3", dv(3));
        idle('0);
        chk_off("R1 deselect phase");
    endtask

    // pending write forwarding and byte lanes
    task automatic t_fwd();
        tk(SEL, 0, 0, 5, 2'b00, '0);
        tk(SEL, 0, 1, 5, 2'b11, '0);
        idle(18'h2468A);
        idle('0);
        chk_rd("R10 forward full word", 18'h2468A);
        tk(SEL, 0, 0, 6, 2'b00, '0);
        tk(SEL, 0, 0, 6, 2'b10, '0);
        tk(SEL, 0, 1, 6, 2'b11, 18'h3FE01);
        idle(18'h00155);
        idle('0);
        chk_rd("R10 R7 merged forward", {9'h1FF, 9'h155});
        tk(SEL, 0, 0, 6, 2'b01, '0);
        idle('0);
        idle(18'h0A6C3);
        idle('0);
        tk(SEL, 0, 1, 6, 2'b11, '0);
        idle('0);
        idle('0);
        chk_rd("R7 upper lane only", {9'h053, 9'h155});
    endtask

    // clock enable stalls
    task automatic t_cke();
        tk(SEL, 0, 1, 0, 2'b11, '0);
        cke_n = 1'b1;
        tk(SEL, 0, 0, 0, 2'b00, 18'h3FFFF);
        tk(SEL, 0, 0, 0, 2'b00, 18'h3FFFF);
        cke_n = 1'b0;
        chk_off("R4 stalled edges not counted");
        idle('0);
        chk_off("R4 one enabled edge");
        idle('0);
        chk_rd("R4 data after two enabled edges", dv(0));
        cke_n = 1'b1;
        tk(SEL, 0, 0, 0, 2'b00, 18'h3FFFF);
        chk_rd("R4 data held in stall", dv(0));
        tk(SEL, 0, 1, 1, 2'b00, 18'h3FFFF);
        chk_rd("R4 data held second stall", dv(0));
        cke_n = 1'b0;
        idle('0);
        idle('0);
        tk(SEL, 0, 1, 0, 2'b11, '0);
        idle('0);
        idle('0);
        chk_rd("R4 stalled write ignored", dv(0));
    endtask

    task automatic t_oe();
        tk(SEL, 0, 1, 1, 2'b11, '0);
        idle('0);
        idle('0);
        chk_rd("R6 read with oe low", dv(1));
        oe_n = 1'b1;
        #1;
        chk_off("R6 oe high floats bus");
        oe_n = 1'b0;
        #1;
        chk_rd("R6 oe low drives again", dv(1));
        idle('0);
        chk_off("R6 idle after read");
    endtask

    task automatic t_desel();
        logic [2:0] combos [3] = '{3'b101, 3'b011, 3'b000};
        for (int c = 0; c < 3; c++) begin
            tk(combos[c], 0, 0, 0, 2'b00, '0);
            tk(combos[c], 0, 1, 0, 2'b11, '0);
            idle(18'h3FFFF);
            idle('0);
            chk_off("R1 unselected read floats");
        end
        tk(SEL, 0, 1, 0, 2'b11, '0);
        idle('0);
        tk(SEL, 0, 1, 1, 2'b11, '0);
        chk_rd("R1 unselected write ignored", dv(0));
        idle('0);
        chk_off("R1 interleaved deselect");
        idle('0);
        chk_rd("R1 read after deselect", dv(1));
    endtask

    task automatic t_burst();
        burst_mode = 1'b0;
        tk(SEL, 0, 0, 10, 2'b00, '0);
        tk(DSL, 1, 1, 0, 2'b00, '0);
        tk(SEL, 1, 1, 0, 2'b00, ev(0));
        tk(SEL, 1, 1, 0, 2'b00, ev(1));
        idle(ev(2));
        idle(ev(3));
        idle('0);
        tk(SEL, 0, 1, 10, 2'b11, '0);
        tk(SEL, 1, 0, 0, 2'b11, '0);
        tk(SEL, 1, 0, 0, 2'b11, '0);
        chk_rd("R9 linear beat0 a10", ev(0));
        tk(SEL, 1, 0, 0, 2'b11, '0);
        chk_rd("R8 linear beat1 a11", ev(1));
        idle('0);
        chk_rd("R9 linear wrap a8", ev(2));
        idle('0);
        chk_rd("R9 linear beat3 a9", ev(3));
        burst_mode = 1'b1;
        tk(SEL, 0, 1, 9, 2'b11, '0);
        tk(SEL, 1, 0, 0, 2'b11, '0);
        tk(SEL, 1, 0, 0, 2'b11, '0);
        chk_rd("R9 interleaved beat0 a9", ev(3));
        tk(SEL, 1, 0, 0, 2'b11, '0);
        chk_rd("R9 interleaved beat1 a8", ev(2));
        tk(SEL, 1, 0, 0, 2'b11, '0);
        chk_rd("R9 interleaved beat2 a11", ev(1));
        idle('0);
        chk_rd("R9 interleaved beat3 a10", ev(0));
        idle('0);
        chk_rd("R9 fifth beat back at base", ev(3));
        tk(SEL, 1, 1, 0, 2'b11, '0);
        idle('0);
        chk_off("R8 continue after deselect");
        idle('0);
        chk_off("R8 continue stays deselected");
        burst_mode = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        finish_up();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_b2b();
        t_fwd();
        t_cke();
        t_oe();
        t_desel();
        t_burst();
        finish_up();
    end

endmodule